// File: doc/BRIEF.md
# ECC Fault Injection Controller

This block sits on the read or write data path of a memory controller and corrupts selected transfers on purpose, so that the ECC checking logic downstream can be validated. Each channel has two control words. The first holds an enable, a half-line selector, an optional address-match qualifier, a first XOR mask and two device pointers. The second holds the XOR mask for the device chosen by the second pointer. One shared response word holds a start code and a stop code for all channels.

Software loads the control words and then writes the response word. Injection starts on the edge where the start code becomes "start now". Once started, a channel corrupts every transfer that meets its conditions, or only the first such transfer, depending on the stop code. A single-shot channel stays quiet afterwards. Writing the same "start now" value a second time has no effect. To fire again, software must first write a "never start" value and then the "start now" value.

The data bus of each channel is split into 16-bit device lanes. A transfer that meets the conditions has the XOR masks applied to the pointed lanes in the same cycle. Every other transfer passes through unchanged.

Top module: `fi_inject_ctrl`

## Requirements
- R1: After reset the response word is 0xAA (single-shot, never start), all control words are zero, no channel is armed, and `xfer_data_o` equals `xfer_data_i`.
- R2: A write with `cfg_addr` = 2·c loads control word A of channel c. A write with `cfg_addr` = 2·c+1 loads bits 15:0 into mask B of channel c. `cfg_addr` = 2·NUM_CH (4 by default) loads bits 7:0 into the response word. Writes to any other address change nothing.
- R3: A response write whose bits 3:0 are 0xB arms every channel from the next cycle, but only when the stored start code is not 0xB. Writing 0xB again while it is already stored does not re-arm.
- R4: A response write whose bits 3:0 are anything other than 0xB (0xA means never start) disarms every channel from the next cycle.
- R5: A stored stop code (response bits 7:4) of 0xB keeps a channel armed through any number of corrupted transfers. Any other stop code, 0xA being the documented single-shot value, disarms the channel after its first corrupted transfer.
- R6: A transfer on channel c is corrupted only when all of these hold: `xfer_valid[c]` is high, channel c is armed, control bit 27 is set, and the half selected by control bits 29:28 matches `xfer_upper[c]`. For bits 29:28, 01 selects the lower half, 10 the upper half, 11 both halves, and 00 neither.
- R7: When control bit 31 is set, a transfer also needs `xfer_addr_hit[c]` high to be corrupted. When bit 31 is clear, `xfer_addr_hit[c]` is ignored.
- R8: In a corrupted transfer, lane `ptr_a` (control bits 4:0) is XORed with mask A (control bits 25:10), and lane `ptr_b` (control bits 9:5) is XORed with mask B. Lane d occupies bits d·16+15 down to d·16 of the channel's slice. If both pointers name the same lane, both masks apply to it. A pointer at or above NUM_DEV touches no lane.
- R9: Channels are independent. Each uses only its own control words, and a single-shot firing on one channel leaves the other channels armed.
- R10: `inj_hit[c]` is high in exactly the cycles in which channel c corrupts a transfer. It is combinational with the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| xfer_valid | input | NUM_CH | Transfer present, one bit per channel |
| xfer_upper | input | NUM_CH | Transfer carries the upper half of the line |
| xfer_addr_hit | input | NUM_CH | External address comparator matched |
| xfer_data_i | input | NUM_CH·NUM_DEV·16 | Incoming data and check bits, channel-major |
| xfer_data_o | output | NUM_CH·NUM_DEV·16 | Data after optional corruption |
| inj_hit | output | NUM_CH | Transfer corrupted this cycle |
| inj_armed | output | NUM_CH | Channel is currently armed |

## Verification
A wrong armed flag shows up at the ports on the first qualifying transfer: either a transfer is corrupted when it should pass, or it passes when it should be corrupted. `inj_armed` exposes the flag directly in the cycle after the write or firing that changed it. A decode error in the control words shows up as a flipped bit in the wrong lane, in the wrong half, or on the wrong channel, in the same cycle as the transfer. The bench compares every output on every clock against a behavioural model. This catches a bad re-arm or a missed single-shot disarm within one transfer of the cause.

// File: rtl/fi_pkg.sv
package fi_pkg;

    localparam int MASK_W = 16;
    localparam int PTR_W  = 5;

    localparam logic [3:0] START_NEVER = 4'hA;
    localparam logic [3:0] START_NOW   = 4'hB;
    localparam logic [3:0] STOP_ONE    = 4'hA;
    localparam logic [3:0] STOP_NEVER  = 4'hB;

    typedef struct packed {
        logic              addr_match_en;
        logic [1:0]        half_sel;
        logic              inj_en;
        logic [MASK_W-1:0] mask_a;
        logic [PTR_W-1:0]  ptr_b;
        logic [PTR_W-1:0]  ptr_a;
    } fi_ctl_t;

endpackage

// File: rtl/fi_regs.sv
module fi_regs
    import fi_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [ADDR_W-1:0]              cfg_addr,
    input  logic [31:0]                    cfg_wdata,
    input  logic [NUM_CH-1:0]              fire_i,
    output fi_ctl_t [NUM_CH-1:0]           ctl_o,
    output logic [NUM_CH-1:0][MASK_W-1:0]  mask_b_o,
    output logic [NUM_CH-1:0]              armed_o,
    output logic                           single_o
);

    localparam int RESP_ADDR = 2 * NUM_CH;

    typedef struct packed {
        fi_ctl_t [NUM_CH-1:0]          ctl;
        logic [NUM_CH-1:0][MASK_W-1:0] mask_b;
        logic [7:0]                    resp;
        logic [NUM_CH-1:0]             armed;
    } regs_t;

    localparam regs_t RST_VAL = '{ctl: '0, mask_b: '0, resp: {STOP_ONE, START_NEVER}, armed: '0};

    regs_t s_d, s_q;
    logic  resp_wr, arm_ev, halt_ev, single;
    logic  unused_bits;

    assign unused_bits = ^{cfg_wdata[30], cfg_wdata[26]};
    assign single      = (s_q.resp[7:4] != STOP_NEVER);

    always_comb begin
        resp_wr = cfg_we && (int'(cfg_addr) == RESP_ADDR);
        arm_ev  = resp_wr && (cfg_wdata[3:0] == START_NOW) && (s_q.resp[3:0] != START_NOW);
        halt_ev = resp_wr && (cfg_wdata[3:0] != START_NOW);
        s_d     = s_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (cfg_we && (int'(cfg_addr) == 2 * c)) begin
                s_d.ctl[c].addr_match_en = cfg_wdata[31];
                s_d.ctl[c].half_sel      = cfg_wdata[29:28];
                s_d.ctl[c].inj_en        = cfg_wdata[27];
                s_d.ctl[c].mask_a        = cfg_wdata[25:10];
                s_d.ctl[c].ptr_b         = cfg_wdata[9:5];
                s_d.ctl[c].ptr_a         = cfg_wdata[4:0];
            end
            if (cfg_we && (int'(cfg_addr) == 2 * c + 1)) begin
                s_d.mask_b[c] = cfg_wdata[MASK_W-1:0];
            end
            if (arm_ev) begin
                s_d.armed[c] = 1'b1;
            end else if (halt_ev) begin
                s_d.armed[c] = 1'b0;
            end else if (fire_i[c] && single) begin
                s_d.armed[c] = 1'b0;
            end
        end
        if (resp_wr) begin
            s_d.resp = cfg_wdata[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= RST_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_o    = s_q.ctl;
    assign mask_b_o = s_q.mask_b;
    assign armed_o  = s_q.armed;
    assign single_o = single;

endmodule

// File: rtl/fi_lane_xor.sv
module fi_lane_xor
    import fi_pkg::*;
#(
    parameter int NUM_DEV = 8,
    localparam int BUS_W  = NUM_DEV * MASK_W
) (
    input  fi_ctl_t           ctl_i,
    input  logic [MASK_W-1:0] mask_b_i,
    input  logic              armed_i,
    input  logic              valid_i,
    input  logic              upper_i,
    input  logic              addr_hit_i,
    input  logic [BUS_W-1:0]  data_i,
    output logic [BUS_W-1:0]  data_o,
    output logic              hit_o
);

    logic half_ok;

    always_comb begin
        half_ok = upper_i ? ctl_i.half_sel[1] : ctl_i.half_sel[0];
        hit_o   = valid_i && armed_i && ctl_i.inj_en && half_ok
                  && (!ctl_i.addr_match_en || addr_hit_i);
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_lane
        localparam logic [PTR_W-1:0] DEV_ID = PTR_W'(d);
        logic [MASK_W-1:0] flip;
        always_comb begin
            flip = '0;
            if (hit_o && (ctl_i.ptr_a == DEV_ID)) flip = flip ^ ctl_i.mask_a;
            if (hit_o && (ctl_i.ptr_b == DEV_ID)) flip = flip ^ mask_b_i;
        end
        assign data_o[d*MASK_W +: MASK_W] = data_i[d*MASK_W +: MASK_W] ^ flip;
    end

endmodule

// File: rtl/fi_inject_ctrl.sv
module fi_inject_ctrl
    import fi_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int NUM_DEV = 8,
    parameter int ADDR_W  = 3,
    localparam int BUS_W  = NUM_DEV * MASK_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [31:0]             cfg_wdata,
    input  logic [NUM_CH-1:0]       xfer_valid,
    input  logic [NUM_CH-1:0]       xfer_upper,
    input  logic [NUM_CH-1:0]       xfer_addr_hit,
    input  logic [NUM_CH*BUS_W-1:0] xfer_data_i,
    output logic [NUM_CH*BUS_W-1:0] xfer_data_o,
    output logic [NUM_CH-1:0]       inj_hit,
    output logic [NUM_CH-1:0]       inj_armed
);

    fi_ctl_t [NUM_CH-1:0]          ctl;
    logic [NUM_CH-1:0][MASK_W-1:0] mask_b;
    logic                          single_mode;

    fi_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .fire_i   (inj_hit),
        .ctl_o    (ctl),
        .mask_b_o (mask_b),
        .armed_o  (inj_armed),
        .single_o (single_mode)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        fi_lane_xor #(
            .NUM_DEV(NUM_DEV)
        ) lane_i (
            .ctl_i     (ctl[c]),
            .mask_b_i  (mask_b[c]),
            .armed_i   (inj_armed[c]),
            .valid_i   (xfer_valid[c]),
            .upper_i   (xfer_upper[c]),
            .addr_hit_i(xfer_addr_hit[c]),
            .data_i    (xfer_data_i[c*BUS_W +: BUS_W]),
            .data_o    (xfer_data_o[c*BUS_W +: BUS_W]),
            .hit_o     (inj_hit[c])
        );
    end

endmodule

// File: rtl/fi_inject_ctrl_chk.sv
module fi_inject_ctrl_chk #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 3,
    parameter int BUS_W  = 128
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we,
    input logic [ADDR_W-1:0]       cfg_addr,
    input logic [31:0]             cfg_wdata,
    input logic [NUM_CH-1:0]       xfer_valid,
    input logic [NUM_CH*BUS_W-1:0] xfer_data_i,
    input logic [NUM_CH*BUS_W-1:0] xfer_data_o,
    input logic [NUM_CH-1:0]       inj_hit,
    input logic [NUM_CH-1:0]       inj_armed,
    input logic                    single_mode
);

    localparam int RESP_ADDR = 2 * NUM_CH;

    logic go_wr, halt_wr;
    assign go_wr   = cfg_we && (int'(cfg_addr) == RESP_ADDR) && (cfg_wdata[3:0] == 4'hB);
    assign halt_wr = cfg_we && (int'(cfg_addr) == RESP_ADDR) && (cfg_wdata[3:0] != 4'hB);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_QUIET_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
            !inj_hit[c] |-> (xfer_data_o[c*BUS_W +: BUS_W] == xfer_data_i[c*BUS_W +: BUS_W])); // R8
        AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
            inj_hit[c] |-> (xfer_valid[c] && inj_armed[c])); // R6
        AST_ONE_SHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
            (inj_hit[c] && single_mode) |=> !inj_armed[c]); // R5
        AST_ARM_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(inj_armed[c]) |-> $past(go_wr)); // R3
        AST_HALT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
            halt_wr |=> !inj_armed[c]); // R4
    end

endmodule

bind fi_inject_ctrl fi_inject_ctrl_chk #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .BUS_W (BUS_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .xfer_valid (xfer_valid),
    .xfer_data_i(xfer_data_i),
    .xfer_data_o(xfer_data_o),
    .inj_hit    (inj_hit),
    .inj_armed  (inj_armed),
    .single_mode(single_mode)
);

// File: tb/fi_inject_ctrl_tb_top.sv
module fi_inject_ctrl_tb_top;

    localparam int NCH  = 2;
    localparam int NDEV = 8;
    localparam int BW   = NDEV * 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [NCH-1:0]    xfer_valid = '0;
    logic [NCH-1:0]    xfer_upper = '0;
    logic [NCH-1:0]    xfer_addr_hit = '0;
    logic [NCH*BW-1:0] xfer_data_i = '0;
    logic [NCH*BW-1:0] xfer_data_o;
    logic [NCH-1:0]    inj_hit;
    logic [NCH-1:0]    inj_armed;

    int    errors = 0;
    int    checks = 0;
    bit    chk_on = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    fi_inject_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .xfer_valid(xfer_valid), .xfer_upper(xfer_upper),
        .xfer_addr_hit(xfer_addr_hit), .xfer_data_i(xfer_data_i),
        .xfer_data_o(xfer_data_o), .inj_hit(inj_hit), .inj_armed(inj_armed)
    );

    // behavioural reference state
    logic [31:0] m_a [NCH] = '{default: 32'h0};
    logic [15:0] m_b [NCH] = '{default: 16'h0};
    logic [7:0]  m_rsp = 8'hAA;
    bit          m_arm [NCH] = '{default: 1'b0};
    bit          m_fire [NCH];

    function automatic bit mdl_hit(int c);
        bit half;
        half = xfer_upper[c] ? m_a[c][29] : m_a[c][28];
        return xfer_valid[c] && m_arm[c] && m_a[c][27] && half
               && (!m_a[c][31] || xfer_addr_hit[c]);
    endfunction

    function automatic logic [BW-1:0] mdl_data(int c);
        logic [BW-1:0] v;
        int pa, pb;
        v  = xfer_data_i[c*BW +: BW];
        pa = int'(m_a[c][4:0]);
        pb = int'(m_a[c][9:5]);
        if (mdl_hit(c)) begin
            if (pa < NDEV) v[pa*16 +: 16] = v[pa*16 +: 16] ^ m_a[c][25:10];
            if (pb < NDEV) v[pb*16 +: 16] = v[pb*16 +: 16] ^ m_b[c];
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rsp = 8'hAA;
            for (int c = 0; c < NCH; c++) begin
                m_a[c] = '0; m_b[c] = '0; m_arm[c] = 1'b0;
            end
        end else begin
            bit go, halt;
            logic [7:0] old_rsp;
            for (int c = 0; c < NCH; c++) m_fire[c] = mdl_hit(c);
            old_rsp = m_rsp;
            go = 1'b0; halt = 1'b0;
            if (cfg_we) begin
                if (cfg_addr < 3'd4) begin
                    if (cfg_addr[0]) m_b[cfg_addr[1]] = cfg_wdata[15:0];
                    else             m_a[cfg_addr[1]] = cfg_wdata;
                end else if (cfg_addr == 3'd4) begin
                    go    = (cfg_wdata[3:0] == 4'hB) && (old_rsp[3:0] != 4'hB);
                    halt  = (cfg_wdata[3:0] != 4'hB);
                    m_rsp = cfg_wdata[7:0];
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (go) m_arm[c] = 1'b1;
                else if (halt) m_arm[c] = 1'b0;
                else if (m_fire[c] && old_rsp[7:4] != 4'hB) m_arm[c] = 1'b0;
            end
        end
    end

    // compare every output away from the active edge (R10 covers inj_hit)
    always @(negedge clk) begin
        if (chk_on) begin
            for (int c = 0; c < NCH; c++) begin
                logic [BW-1:0] ed;
                bit eh;
                ed = mdl_data(c);
                eh = mdl_hit(c);
                checks += 3;
                if (xfer_data_o[c*BW +: BW] !== ed) begin
                    errors++;
                    $display("FAIL %s ch%0d data actual=%h expected=%h", cur_req, c,
                             xfer_data_o[c*BW +: BW], ed);
                end
                if (inj_hit[c] !== eh) begin
                    errors++;
                    $display("FAIL %s R10 ch%0d inj_hit actual=%b expected=%b", cur_req, c,
                             inj_hit[c], eh);
                end
                if (inj_armed[c] !== m_arm[c]) begin
                    errors++;
                    $display("FAIL %s ch%0d inj_armed actual=%b expected=%b", cur_req, c,
                             inj_armed[c], m_arm[c]);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        xfer_data_i = {8{$urandom}};
    endtask

    task automatic cfg(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic xf(input int c, input bit up, input bit ah);
        xfer_valid[c] = 1'b1; xfer_upper[c] = up; xfer_addr_hit[c] = ah;
        step();
        xfer_valid = '0; xfer_upper = '0; xfer_addr_hit = '0;
    endtask

    function automatic logic [31:0] ctl_word(bit am, logic [1:0] hs, bit en,
                                              logic [15:0] ma, logic [4:0] pb, logic [4:0] pa);
        return {am, 1'b0, hs, en, 1'b0, ma, pb, pa};
    endfunction

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog %s actual=running expected=finished", cur_req);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none

        // R1: reset state
        cur_req = "R1";
        step(); step();
        chk_on = 1'b1;
        step(); step();
        rst_n = 1'b1;
        step(); step(); step();

        // R2: decode, including ignored addresses 5..7
        cur_req = "R2";
        cfg(3'd0, ctl_word(0, 2'b01, 1, 16'h00FF, 5'd5, 5'd2));
        cfg(3'd1, 32'hFFFF_A5A5);
        cfg(3'd6, 32'hFFFF_FFAB);
        cfg(3'd7, 32'h0000_00AB);
        cfg(3'd5, 32'h0000_00BB);
        xf(0, 0, 0);
        step();

        // R3: arm by never-start then start-now
        cur_req = "R3";
        cfg(3'd4, 32'hAA);
        cfg(3'd4, 32'hAB);
        cur_req = "R6";
        xf(0, 1, 0);                 // upper half not selected
        cur_req = "R5";
        xf(0, 0, 0);                 // fires once
        xf(0, 0, 0);                 // single-shot: quiet now
        cur_req = "R3";
        cfg(3'd4, 32'hAB);           // same value: no re-arm
        xf(0, 0, 0);

        // R5: continuous mode
        cur_req = "R5";
        cfg(3'd4, 32'hAA);
        cfg(3'd4, 32'hBB);
        xf(0, 0, 0); xf(0, 0, 1); xf(0, 0, 0);

        // R4: never-start disarms
        cur_req = "R4";
        cfg(3'd4, 32'hBA);
        xf(0, 0, 0);
        cfg(3'd4, 32'hBB);

        // R6: half select and enable
        cur_req = "R6";
        cfg(3'd0, ctl_word(0, 2'b00, 1, 16'h1234, 5'd1, 5'd0));
        xf(0, 0, 0); xf(0, 1, 0);
        cfg(3'd0, ctl_word(0, 2'b11, 1, 16'h1234, 5'd1, 5'd0));
        xf(0, 0, 0); xf(0, 1, 0);
        cfg(3'd0, ctl_word(0, 2'b10, 1, 16'h1234, 5'd1, 5'd0));
        xf(0, 0, 0); xf(0, 1, 0);
        cfg(3'd0, ctl_word(0, 2'b11, 0, 16'h1234, 5'd1, 5'd0));
        xf(0, 0, 0); xf(0, 1, 0);

        // R7: address-match qualifier
        cur_req = "R7";
        cfg(3'd0, ctl_word(1, 2'b11, 1, 16'hF00F, 5'd4, 5'd6));
        xf(0, 0, 0); xf(0, 1, 1); xf(0, 0, 1);

        // R8: lane placement, shared pointer, out-of-range pointer
        cur_req = "R8";
        cfg(3'd0, ctl_word(0, 2'b11, 1, 16'h0F0F, 5'd3, 5'd3));
        cfg(3'd1, 32'h0000_3C3C);
        xf(0, 0, 0);
        cfg(3'd0, ctl_word(0, 2'b11, 1, 16'hFFFF, 5'd7, 5'd9));
        xf(0, 1, 0);
        cfg(3'd0, ctl_word(0, 2'b11, 1, 16'h8001, 5'd20, 5'd0));
        xf(0, 0, 0);

        // R9: independent channels, single-shot each
        cur_req = "R9";
        cfg(3'd2, ctl_word(0, 2'b11, 1, 16'hC0DE, 5'd0, 5'd1));
        cfg(3'd3, 32'h0000_BEEF);
        cfg(3'd0, ctl_word(0, 2'b01, 1, 16'h0101, 5'd2, 5'd7));
        cfg(3'd4, 32'hAA);
        cfg(3'd4, 32'hAB);
        xf(1, 1, 0);                 // channel 1 fires, channel 0 stays armed
        xf(1, 0, 0);
        xf(0, 0, 0);                 // channel 0 fires
        cfg(3'd4, 32'hAA);
        cfg(3'd4, 32'hAB);
        xfer_valid = 2'b11; xfer_upper = 2'b00;
        step();                      // both channels in one cycle
        xfer_valid = '0;
        step(); step();

        chk_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule